// File: doc/BRIEF.md
# Command-Queued Memory Port

This block is a behavioural model of the user side of a memory controller port. It is driven by commands. A client first loads data words into a write-data queue. It then posts a command that carries an opcode, a burst length and a starting byte address. The port takes commands from a small command queue strictly in arrival order and executes one at a time, moving one 64-bit word per clock.

A write command moves data from the write-data queue into an on-chip word array. Each byte of a write can be suppressed by a per-byte mask bit. A read command copies array words into a read-data queue. The client drains that queue with a show-ahead pop: `rd_data` already holds the head word.

Fill counts and full/empty flags make the queues visible to the client. Two sticky flags report misuse:
- a write that starts with too little data sets the write-underrun flag;
- a read word that finds the read queue full sets the read-overflow flag.

The port accepts nothing until its calibration-done output rises, a fixed number of cycles after reset is released. All logic runs on one clock with a synchronous active-low reset.

Top module: `cmdq_mem_port`

## Requirements
- R1: While reset is held and on the first cycle after it, all three queues are empty, both fill counts are 0, every full flag is low, `wr_underrun` and `rd_overflow` are low, and `calib_done` is low.
- R2: `calib_done` rises on the (CAL_CYCLES+1)-th rising clock edge after reset is released, and then stays high until the next reset. CAL_CYCLES defaults to 64.
- R3: `cmd_en`, `wr_en` and `rd_en` have no effect while `calib_done` is low.
- R4: Opcode 3'b000 is a write. It moves `cmd_len`+1 words from the write queue into consecutive array words. Opcode 3'b001 is a read. It appends `cmd_len`+1 consecutive array words to the read queue in ascending address order. `rd_data` shows the head word whenever the read queue is not empty, and `rd_en` removes that word.
- R5: In a written word, a set `wr_mask[b]` leaves byte b (bits 8b+7..8b) of the array word unchanged. A clear bit stores that byte from `wr_data`.
- R6: The write queue holds 64 words. `wrq_count` shows its fill level from 0 to 64, `wrq_full` is high exactly at 64, and `wrq_empty` is high exactly at 0. A push while the queue is full is ignored.
- R7: The read queue holds 64 words. `rdq_count`, `rdq_full` and `rdq_empty` follow the same rules as for the write queue. `rd_en` on an empty read queue is ignored.
- R8: A read word produced while the read queue is full is dropped, and `rd_overflow` is set.
- R9: If a write command starts while the write queue holds fewer than `cmd_len`+1 words, `wr_underrun` is set. The command then waits for the missing words and completes with the correct data.
- R10: The command queue holds 4 commands and `cmdq_full` reports when it is full. A command posted while it is full is ignored. Commands run in the order they were posted.
- R11: A command's word index is byte address bits [10:3] (for a 256-word array). The low three address bits are ignored, and consecutive words wrap modulo the array size. A 16-word burst spans 128 bytes.
- R12: A command whose opcode is neither 3'b000 nor 3'b001 is discarded and moves no data.
- R13: `wr_underrun` and `rd_overflow` stay high once set, and only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| calib_done | output | 1 | High once the port accepts traffic |
| cmd_en | input | 1 | Post a command |
| cmd_op | input | 3 | Opcode: 000 write, 001 read |
| cmd_len | input | 6 | Burst length minus one |
| cmd_addr | input | 30 | Starting byte address |
| cmdq_full | output | 1 | Command queue full |
| cmdq_empty | output | 1 | Command queue empty |
| wr_en | input | 1 | Push a word into the write queue |
| wr_data | input | 64 | Write word |
| wr_mask | input | 8 | Per-byte write suppress |
| wrq_full | output | 1 | Write queue full |
| wrq_empty | output | 1 | Write queue empty |
| wrq_count | output | 7 | Write queue fill level |
| wr_underrun | output | 1 | Sticky: a write started short of data |
| rd_en | input | 1 | Pop the read queue head |
| rd_data | output | 64 | Read queue head word |
| rdq_full | output | 1 | Read queue full |
| rdq_empty | output | 1 | Read queue empty |
| rdq_count | output | 7 | Read queue fill level |
| rd_overflow | output | 1 | Sticky: a read word was dropped |

## Verification
The bench first fills the whole array with unmasked data. It then runs seeded random bursts with random lengths, masks, unaligned byte addresses and wrap-around, and compares every returned word with a byte-merging reference model. A design that ignored the mask, or that used the low address bits, would return words that differ from the model. Directed cases cover the following:
- pushes into a full write queue, which a faulty design would count or store;
- a read into a full read queue, which must drop the word and set the overflow flag instead of overwriting;
- a write issued with no data, which must set underrun, stall while four more commands fill the command queue so that a fifth is dropped, and then complete in order;
- an unknown opcode, which must leave both data queues unchanged;
- traffic offered during calibration, which a faulty design would accept.

// File: rtl/cmdq_pkg.sv
// Shared types and constants for the command-queued memory port.
// Assumes: 64-bit data words, byte masks, 30-bit byte addresses.
package cmdq_pkg;
    localparam int DATA_W = 64;
    localparam int MASK_W = DATA_W / 8;
    localparam int ADDR_W = 30;
    localparam int LEN_W  = 6;
    localparam int OP_W   = 3;

    localparam logic [OP_W-1:0] OP_WRITE = 3'b000;
    localparam logic [OP_W-1:0] OP_READ  = 3'b001;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } mp_cmd_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [DATA_W-1:0] data;
    } mp_wword_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_WRITE = 2'd1,
        ENG_READ  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/cmdq_fifo.sv
// Single-clock show-ahead FIFO with fill count and full/empty flags.
// Does: pushes when full and pops when empty are ignored; dout shows the head.
// Assumes: DEPTH is a power of two.
module cmdq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    // Qualify requests against the current fill level.
    always_comb begin
        do_push = push && (cnt != FULL_LVL);
        do_pop  = pop && (cnt != '0);
    end

    // Pointer and fill-level update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) store[wp] <= din;
    end

    assign dout  = store[rp];
    assign full  = (cnt == FULL_LVL);
    assign empty = (cnt == '0);
    assign count = cnt;

    assert_full_push_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(count));
    assert_empty_pop_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> $stable(count));
endmodule

// File: rtl/cmdq_calib_timer.sv
// Calibration stand-in: raises done a fixed count after reset release.
// Assumes: CAL_CYCLES >= 1; done stays high until the next reset.
module cmdq_calib_timer #(
    parameter int CAL_CYCLES = 64,
    localparam int CW        = $clog2(CAL_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES);
    logic [CW-1:0] cnt;

    // Count cycles since reset, then latch done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (cnt == LAST) begin
            done <= 1'b1;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assert_calib_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: rtl/cmdq_engine.sv
// Command executor and word array.
// Does: runs one command at a time, one word per clock; writes merge masked
//       bytes into the array, reads append array words to the read queue.
// Assumes: the write queue head is valid when not empty; the read queue
//          accepts a push whenever it is not full.
module cmdq_engine
    import cmdq_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int CNT_W     = 7,
    localparam int AW       = $clog2(MEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  mp_cmd_t            cmd_in,
    output logic               cmd_pop,
    input  logic               wq_empty,
    input  logic [CNT_W-1:0]   wq_count,
    input  mp_wword_t          wq_head,
    output logic               wq_pop,
    input  logic               rq_full,
    output logic               rq_push,
    output logic [DATA_W-1:0]  rq_din,
    output logic               underrun,
    output logic               overflow
);
    eng_state_t       state;
    logic [AW-1:0]    ptr;
    logic [LEN_W-1:0] left;
    logic             short_start;

    wire unused_addr_bits = ^{cmd_in.addr[ADDR_W-1:AW+3], cmd_in.addr[2:0]};

    // Handshakes derived from the current state.
    always_comb begin
        cmd_pop     = (state == ENG_IDLE) && cmd_valid;
        wq_pop      = (state == ENG_WRITE) && !wq_empty;
        rq_push     = (state == ENG_READ) && !rq_full;
        short_start = int'(wq_count) < (int'(cmd_in.len) + 1);
    end

    // Sequencer: accept a command, then step through its words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            ptr      <= '0;
            left     <= '0;
            underrun <= 1'b0;
            overflow <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: if (cmd_valid) begin
                    ptr  <= cmd_in.addr[AW+2:3];
                    left <= cmd_in.len;
                    if (cmd_in.op == OP_WRITE) begin
                        state <= ENG_WRITE;
                        if (short_start) underrun <= 1'b1;
                    end else if (cmd_in.op == OP_READ) begin
                        state <= ENG_READ;
                    end
                end
                ENG_WRITE: if (!wq_empty) begin
                    ptr  <= ptr + AW'(1);
                    left <= left - LEN_W'(1);
                    if (left == '0) state <= ENG_IDLE;
                end
                ENG_READ: begin
                    if (rq_full) overflow <= 1'b1;
                    ptr  <= ptr + AW'(1);
                    left <= left - LEN_W'(1);
                    if (left == '0) state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // One storage lane per byte so the mask gates each byte's write.
    for (genvar b = 0; b < MASK_W; b++) begin : g_lane
        logic [7:0] lane_q [MEM_WORDS];
        // Byte write, suppressed by the mask bit.
        always_ff @(posedge clk) begin
            if (wq_pop && !wq_head.mask[b]) lane_q[ptr] <= wq_head.data[b*8 +: 8];
        end
        assign rq_din[b*8 +: 8] = lane_q[ptr];
    end

    assert_underrun_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    assert_overflow_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_overflow_on_full_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_READ && rq_full) |=> overflow);
    assert_write_ends_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_WRITE && left == '0 && wq_pop) |=> (state == ENG_IDLE));
    assert_one_queue_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wq_pop && rq_push));
endmodule

// File: rtl/cmdq_mem_port.sv
// Top of the command-queued memory port.
// Does: gates all client traffic on calibration, queues commands, write
//       words and read words, and runs the engine over the word array.
// Assumes: one clock domain; synchronous active-low reset.
module cmdq_mem_port
    import cmdq_pkg::*;
#(
    parameter int MEM_WORDS    = 256,
    parameter int DATA_Q_DEPTH = 64,
    parameter int CMD_Q_DEPTH  = 4,
    parameter int CAL_CYCLES   = 64,
    localparam int CNT_W       = $clog2(DATA_Q_DEPTH) + 1,
    localparam int CQ_CW       = $clog2(CMD_Q_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              calib_done,
    input  logic              cmd_en,
    input  logic [2:0]        cmd_op,
    input  logic [5:0]        cmd_len,
    input  logic [29:0]       cmd_addr,
    output logic              cmdq_full,
    output logic              cmdq_empty,
    input  logic              wr_en,
    input  logic [63:0]       wr_data,
    input  logic [7:0]        wr_mask,
    output logic              wrq_full,
    output logic              wrq_empty,
    output logic [CNT_W-1:0]  wrq_count,
    output logic              wr_underrun,
    input  logic              rd_en,
    output logic [63:0]       rd_data,
    output logic              rdq_full,
    output logic              rdq_empty,
    output logic [CNT_W-1:0]  rdq_count,
    output logic              rd_overflow
);
    mp_cmd_t           cmd_new, cmd_head;
    mp_wword_t         wword_new, wword_head;
    logic              cmd_push, cmd_pop, wq_push, wq_pop, rq_push, rq_pop;
    logic [DATA_W-1:0] rq_din;
    logic [CQ_CW-1:0]  unused_cmdq_count;

    // Client requests count only once calibration is done.
    always_comb begin
        cmd_push  = cmd_en && calib_done;
        wq_push   = wr_en && calib_done;
        rq_pop    = rd_en && calib_done;
        cmd_new   = '{op: cmd_op, len: cmd_len, addr: cmd_addr};
        wword_new = '{mask: wr_mask, data: wr_data};
    end

    cmdq_calib_timer #(.CAL_CYCLES(CAL_CYCLES)) calib_i (
        .clk(clk), .rst_n(rst_n), .done(calib_done));

    cmdq_fifo #(.W($bits(mp_cmd_t)), .DEPTH(CMD_Q_DEPTH)) cmdq_i (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_new),
        .pop(cmd_pop), .dout(cmd_head), .full(cmdq_full), .empty(cmdq_empty),
        .count(unused_cmdq_count));

    cmdq_fifo #(.W($bits(mp_wword_t)), .DEPTH(DATA_Q_DEPTH)) wrq_i (
        .clk(clk), .rst_n(rst_n), .push(wq_push), .din(wword_new),
        .pop(wq_pop), .dout(wword_head), .full(wrq_full), .empty(wrq_empty),
        .count(wrq_count));

    cmdq_fifo #(.W(DATA_W), .DEPTH(DATA_Q_DEPTH)) rdq_i (
        .clk(clk), .rst_n(rst_n), .push(rq_push), .din(rq_din),
        .pop(rq_pop), .dout(rd_data), .full(rdq_full), .empty(rdq_empty),
        .count(rdq_count));

    cmdq_engine #(.MEM_WORDS(MEM_WORDS), .CNT_W(CNT_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(!cmdq_empty), .cmd_in(cmd_head),
        .cmd_pop(cmd_pop), .wq_empty(wrq_empty), .wq_count(wrq_count),
        .wq_head(wword_head), .wq_pop(wq_pop), .rq_full(rdq_full),
        .rq_push(rq_push), .rq_din(rq_din), .underrun(wr_underrun),
        .overflow(rd_overflow));

    assert_no_traffic_before_calib_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !calib_done |-> (cmdq_empty && wrq_empty && rdq_empty));
    assert_cmd_full_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmdq_full && cmd_en && !cmd_pop) |=> cmdq_full);
endmodule

// File: tb/cmdq_mem_port_tb_top.sv
module cmdq_mem_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 256;
    localparam int QD         = 64;
    localparam int CAL        = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        calib_done;
    logic        cmd_en = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [5:0]  cmd_len = '0;
    logic [29:0] cmd_addr = '0;
    logic        cmdq_full, cmdq_empty;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_mask = '0;
    logic        wrq_full, wrq_empty;
    logic [6:0]  wrq_count;
    logic        wr_underrun;
    logic        rd_en = 1'b0;
    logic [63:0] rd_data;
    logic        rdq_full, rdq_empty;
    logic [6:0]  rdq_count;
    logic        rd_overflow;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] ref_mem [MEM_WORDS];
    logic [71:0] pend_q [$];
    logic [63:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdq_mem_port #(.MEM_WORDS(MEM_WORDS), .DATA_Q_DEPTH(QD), .CMD_Q_DEPTH(4),
                    .CAL_CYCLES(CAL)) dut_i (
        .clk(clk), .rst_n(rst_n), .calib_done(calib_done),
        .cmd_en(cmd_en), .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_addr(cmd_addr),
        .cmdq_full(cmdq_full), .cmdq_empty(cmdq_empty),
        .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
        .wrq_full(wrq_full), .wrq_empty(wrq_empty), .wrq_count(wrq_count),
        .wr_underrun(wr_underrun), .rd_en(rd_en), .rd_data(rd_data),
        .rdq_full(rdq_full), .rdq_empty(rdq_empty), .rdq_count(rdq_count),
        .rd_overflow(rd_overflow));

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        report();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                          input logic [7:0] m);
        logic [63:0] r = old;
        for (int b = 0; b < 8; b++) if (!m[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(input logic [63:0] d, input logic [7:0] m, input bit track);
        wr_en = 1'b1; wr_data = d; wr_mask = m;
        if (track) pend_q.push_back({m, d});
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic post_cmd(input logic [2:0] op, input logic [5:0] len, input logic [29:0] a);
        cmd_en = 1'b1; cmd_op = op; cmd_len = len; cmd_addr = a;
        tick(1);
        cmd_en = 1'b0;
    endtask

    // Reference model of a write command: consume pending words.
    task automatic model_write(input int len, input logic [29:0] a);
        int idx = int'(a[10:3]);
        for (int k = 0; k <= len; k++) begin
            logic [71:0] w = pend_q.pop_front();
            ref_mem[(idx + k) % MEM_WORDS] = merge(ref_mem[(idx + k) % MEM_WORDS], w[63:0], w[71:64]);
        end
    endtask

    // Reference model of a read command: words beyond free space are dropped.
    task automatic model_read(input int len, input logic [29:0] a);
        int idx = int'(a[10:3]);
        for (int k = 0; k <= len; k++)
            if (exp_q.size() < QD) exp_q.push_back(ref_mem[(idx + k) % MEM_WORDS]);
    endtask

    task automatic pop_word(output logic [63:0] v);
        v = rd_data;
        rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
    endtask

    task automatic drain(input string req);
        logic [63:0] v, e;
        chk(int'(rdq_count) == exp_q.size(), req, "read queue level", 64'(rdq_count), 64'(exp_q.size()));
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            pop_word(v);
            chk(v === e, req, "read word", v, e);
        end
    endtask

    task automatic write_burst(input int len, input logic [29:0] a, input bit masked);
        for (int i = 0; i <= len; i++)
            push_word({$urandom, $urandom}, masked ? 8'($urandom) : 8'h00, 1'b1);
        post_cmd(3'b000, 6'(len), a);
        model_write(len, a);
        tick(len + 6);
    endtask

    task automatic read_burst(input int len, input logic [29:0] a);
        post_cmd(3'b001, 6'(len), a);
        model_read(len, a);
        tick(len + 6);
    endtask

    initial begin
        logic [63:0] v;
        void'($urandom(32'd2024));
        tick(3);
        // R1: state while reset is held
        chk(cmdq_empty && wrq_empty && rdq_empty, "R1", "queues empty", 0, 1);
        chk(wrq_count == 0 && rdq_count == 0, "R1", "counts", {wrq_count, rdq_count}, 0);
        chk(!cmdq_full && !wrq_full && !rdq_full, "R1", "full flags", 0, 0);
        chk(!wr_underrun && !rd_overflow, "R1", "error flags", {wr_underrun, rd_overflow}, 0);
        chk(!calib_done, "R1", "calib_done", 64'(calib_done), 0);

        // R3: traffic offered throughout calibration
        rst_n = 1'b1;
        wr_en = 1'b1; wr_data = 64'h55; cmd_en = 1'b1; cmd_op = 3'b001; rd_en = 1'b1;
        tick(CAL);
        chk(!calib_done, "R2", "calib_done after CAL edges", 64'(calib_done), 0);
        chk(wrq_empty && wrq_count == 0, "R3", "write queue before calib", 64'(wrq_count), 0);
        chk(cmdq_empty && rdq_empty, "R3", "cmd/read queues before calib", 0, 1);
        wr_en = 1'b0; cmd_en = 1'b0; rd_en = 1'b0;
        tick(1);
        chk(calib_done, "R2", "calib_done after CAL+1 edges", 64'(calib_done), 1);

        // R7: pop on empty read queue ignored
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
        chk(rdq_empty && rdq_count == 0, "R7", "pop on empty", 64'(rdq_count), 0);

        // R6: fill the write queue, then write the whole array unmasked
        for (int b = 0; b < MEM_WORDS / QD; b++) begin
            for (int i = 0; i < QD; i++) push_word({$urandom, $urandom}, 8'h00, 1'b1);
            if (b == 0) begin
                chk(wrq_full && wrq_count == 7'd64, "R6", "write queue full", 64'(wrq_count), 64);
                push_word(64'hDEAD, 8'h00, 1'b0);
                chk(wrq_count == 7'd64, "R6", "push on full ignored", 64'(wrq_count), 64);
            end
            post_cmd(3'b000, 6'd63, 30'(b * QD * 8));
            model_write(63, 30'(b * QD * 8));
            tick(QD + 6);
            chk(wrq_empty && wrq_count == 0, "R6", "write queue drained", 64'(wrq_count), 0);
        end

        // R4 / R11: two 16-word bursts 128 bytes apart
        read_burst(15, 30'd0);
        read_burst(15, 30'd128);
        chk(rdq_count == 7'd32 && !rdq_empty, "R7", "read queue level", 64'(rdq_count), 32);
        drain("R4");

        // R11: low address bits ignored, wrap at the end of the array
        read_burst(0, 30'(5 * 8 + 3));
        read_burst(1, 30'((MEM_WORDS - 1) * 8));
        drain("R11");

        // R5 / R4: random bursts with masks and unaligned addresses
        for (int it = 0; it < 24; it++) begin
            int len = int'($urandom % 16);
            logic [29:0] a = 30'($urandom);
            write_burst(len, a, 1'b1);
            read_burst(len, a);
            drain("R5");
        end

        // R12: unknown opcodes move no data
        for (int i = 0; i < 3; i++) push_word({$urandom, $urandom}, 8'h00, 1'b1);
        post_cmd(3'b010, 6'd2, 30'd0);
        post_cmd(3'b111, 6'd2, 30'd0);
        tick(10);
        chk(wrq_count == 7'd3 && rdq_empty && cmdq_empty, "R12", "unknown opcode", 64'(wrq_count), 3);
        post_cmd(3'b000, 6'd2, 30'(8 * 200));
        model_write(2, 30'(8 * 200));
        tick(10);
        read_burst(2, 30'(8 * 200));
        drain("R12");

        // R8: read into a full read queue
        read_burst(63, 30'd0);
        chk(rdq_full && rdq_count == 7'd64 && !rd_overflow, "R8", "full, no overflow yet", 64'(rd_overflow), 0);
        read_burst(1, 30'(8 * 100));
        chk(rd_overflow, "R8", "overflow set", 64'(rd_overflow), 1);
        chk(rdq_count == 7'd64, "R8", "dropped word not stored", 64'(rdq_count), 64);
        drain("R8");

        // R9 / R10: write with no data stalls while commands queue up
        post_cmd(3'b000, 6'd3, 30'(8 * 40));
        tick(3);
        chk(wr_underrun, "R9", "underrun set", 64'(wr_underrun), 1);
        for (int i = 0; i < 4; i++) post_cmd(3'b001, 6'd3, 30'(8 * 40));
        chk(cmdq_full, "R10", "command queue full", 64'(cmdq_full), 1);
        post_cmd(3'b001, 6'd3, 30'(8 * 40));
        for (int i = 0; i < 4; i++) push_word({$urandom, $urandom}, 8'h00, 1'b1);
        model_write(3, 30'(8 * 40));
        for (int i = 0; i < 4; i++) model_read(3, 30'(8 * 40));
        tick(40);
        chk(rdq_count == 7'd16 && wrq_empty, "R10", "fifth command ignored", 64'(rdq_count), 16);
        drain("R9");
        chk(wr_underrun && rd_overflow, "R13", "flags still set", {wr_underrun, rd_overflow}, 2'b11);

        // R13: only reset clears the sticky flags
        rst_n = 1'b0;
        tick(2);
        chk(!wr_underrun && !rd_overflow, "R13", "flags cleared by reset", {wr_underrun, rd_overflow}, 0);
        chk(!calib_done, "R1", "calib_done low in reset", 64'(calib_done), 0);
        report();
    end
endmodule